// File: doc/BRIEF.md
# Memory alignment check unit

This block sits beside a load/store path and inspects every memory access request before it proceeds. Each request carries the low bits of its address, the operand size, the privilege level of the code that issued it, and a flag saying whether the access is an implicit supervisor reference. Examples of implicit supervisor references are table or descriptor fetches that the machine makes on behalf of an instruction. The block raises an alignment exception for a misaligned operand, but only when two enable bits are set, the access runs at user privilege, and it is not an implicit supervisor reference.

A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. When that request faults, `faultPulse` goes high for the single cycle that follows the acceptance edge. In that cycle `faultVector` shows the exception number. The address and size of the faulting access stay latched until the next fault. A saturating counter records how many faults have been raised.

Top module: `align_check_unit`

## Requirements
- R1: A fault can be raised only when `acFlag` and `amCtrl` are both 1. If either is 0, no request faults.
- R2: For a half-word access (`reqSize` = 1, 2 bytes), the access faults when address bit 0 is 1.
- R3: For a word access (`reqSize` = 2, 4 bytes), the access faults when address bits [1:0] are not both 0.
- R4: For a double-word access (`reqSize` = 3, 8 bytes), the access faults when address bits [2:0] are not all 0.
- R5: A byte access (`reqSize` = 0) never faults.
- R6: Only requests with `reqPriv` = 3 (user level) can fault. Levels 0, 1 and 2 never fault.
- R7: A request with `reqImplicitSup` = 1 never faults, whatever its privilege level.
- R8: For a faulting request accepted at a clock edge, `faultPulse` is 1 for exactly the following cycle. `faultVector` reads 17 while `faultPulse` is 1 and reads 0 otherwise.
- R9: On each fault, `faultAddr` and `faultSize` capture the request's address and size. They keep those values until the next fault.
- R10: `faultCount` increases by one per fault and stops at its maximum value, 2^CNT_W-1.
- R11: During reset and in the first cycle after it, `reqReady` is 0. Reset clears all outputs to 0. After that first cycle, `reqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Linear address of the access |
| reqSize | input | 2 | Log2 of the access size in bytes (0..3) |
| reqPriv | input | 2 | Privilege level of the request (3 = user) |
| reqImplicitSup | input | 1 | Access is an implicit supervisor reference |
| acFlag | input | 1 | Alignment-check flag |
| amCtrl | input | 1 | Alignment-mask control bit |
| faultPulse | output | 1 | One-cycle alignment exception strobe |
| faultVector | output | 8 | Exception number (17) while pulsing, else 0 |
| faultAddr | output | ADDR_W | Address of the last faulting access |
| faultSize | output | 2 | Size code of the last faulting access |
| faultCount | output | CNT_W | Saturating fault counter |

## Verification
The bench builds the block with ADDR_W = 8 and CNT_W = 4. The narrow address lets the bench sweep every address against every size, privilege level, implicit flag and enable combination, which is 32768 requests. The 4-bit counter reaches saturation at 15 early in the enabled user-level part of that sweep. The remaining faults then confirm that the counter stays at 15 while the latched address and size keep updating.

// File: rtl/align_check_pkg.sv
package align_check_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } accSize_e;

  typedef struct packed {
    logic raise;   // emit the exception pulse
    logic latch;   // capture address/size and count
  } ctrlStrobes_t;

  localparam logic [7:0] ALIGN_VECTOR = 8'd17;
  localparam logic [1:0] USER_PRIV    = 2'd3;
endpackage

// File: rtl/align_check_ctrl.sv
module align_check_ctrl
  import align_check_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic [2:0]   addrLow,
  input  logic [1:0]   reqSize,
  input  logic [1:0]   reqPriv,
  input  logic         reqImplicitSup,
  input  logic         acFlag,
  input  logic         amCtrl,
  output ctrlStrobes_t strobes
);
  logic readyQ;
  logic accept;
  logic misaligned;
  logic checkOn;

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end
  assign reqReady = readyQ;
  assign accept   = reqValid && readyQ;

  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = addrLow[0];
      SZ_WORD: misaligned = |addrLow[1:0];
      SZ_DBL:  misaligned = |addrLow[2:0];
      default: misaligned = 1'b0;
    endcase
  end

  assign checkOn = acFlag && amCtrl && (reqPriv == USER_PRIV) && !reqImplicitSup;

  always_comb begin
    strobes.raise = accept && checkOn && misaligned;
    strobes.latch = accept && checkOn && misaligned;
  end

  // R1: either enable low blocks the exception
  a_r1_enables_gate: assert property (@(posedge clk) disable iff (!rstN)
    !(acFlag && amCtrl) |-> !strobes.raise);
  // R5: byte accesses are always aligned
  a_r5_byte_safe: assert property (@(posedge clk) disable iff (!rstN)
    (reqSize == 2'd0) |-> !strobes.raise);
  // R6 / R7: non-user and implicit supervisor accesses are exempt
  a_r6_user_only: assert property (@(posedge clk) disable iff (!rstN)
    (reqPriv != USER_PRIV || reqImplicitSup) |-> !strobes.raise);
  // R11: nothing is accepted while not ready
  a_r11_no_accept_unready: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> !strobes.latch);
endmodule

// File: rtl/align_check_dp.sv
module align_check_dp
  import align_check_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output logic              faultPulse,
  output logic [7:0]        faultVector,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [1:0]        faultSize,
  output logic [CNT_W-1:0]  faultCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic pulseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseQ     <= 1'b0;
      faultAddr  <= '0;
      faultSize  <= '0;
      faultCount <= '0;
    end else begin
      pulseQ <= strobes.raise;
      if (strobes.latch) begin
        faultAddr <= reqAddr;
        faultSize <= reqSize;
        if (faultCount != CNT_MAX) faultCount <= faultCount + 1'b1;
      end
    end
  end

  assign faultPulse  = pulseQ;
  assign faultVector = pulseQ ? ALIGN_VECTOR : 8'd0;

  // R8: pulse follows a raise by one cycle and only then
  a_r8_pulse_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobes.raise |=> faultPulse);
  a_r8_pulse_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.raise |=> !faultPulse);
  // R9: captured fields hold without a new fault
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latch |=> ($stable(faultAddr) && $stable(faultSize)));
  // R10: counter steps by one below the ceiling, sticks at it
  a_r10_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latch && faultCount != CNT_MAX) |=> faultCount == $past(faultCount) + 1'b1);
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (faultCount == CNT_MAX) |=> faultCount == CNT_MAX);
endmodule

// File: rtl/align_check_unit.sv
module align_check_unit
  import align_check_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqPriv,
  input  logic              reqImplicitSup,
  input  logic              acFlag,
  input  logic              amCtrl,
  output logic              faultPulse,
  output logic [7:0]        faultVector,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [1:0]        faultSize,
  output logic [CNT_W-1:0]  faultCount
);
  ctrlStrobes_t strobes;

  align_check_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .addrLow(reqAddr[2:0]), .reqSize(reqSize), .reqPriv(reqPriv),
    .reqImplicitSup(reqImplicitSup), .acFlag(acFlag), .amCtrl(amCtrl),
    .strobes(strobes)
  );

  align_check_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqSize(reqSize), .faultPulse(faultPulse), .faultVector(faultVector),
    .faultAddr(faultAddr), .faultSize(faultSize), .faultCount(faultCount)
  );
endmodule

// File: tb/align_check_unit_test.sv
`timescale 1ns/1ps
module align_check_unit_test;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic [1:0] reqPriv = '0;
  logic reqImplicitSup = 1'b0;
  logic acFlag = 1'b0;
  logic amCtrl = 1'b0;
  logic faultPulse;
  logic [7:0] faultVector;
  logic [ADDR_W-1:0] faultAddr;
  logic [1:0] faultSize;
  logic [CNT_W-1:0] faultCount;

  int nChecks = 0;
  int nFails = 0;
  int expCount = 0;
  int expAddr = 0;
  int expSize = 0;

  always #2 clk = ~clk;

  align_check_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqPriv(reqPriv),
    .reqImplicitSup(reqImplicitSup), .acFlag(acFlag), .amCtrl(amCtrl),
    .faultPulse(faultPulse), .faultVector(faultVector), .faultAddr(faultAddr),
    .faultSize(faultSize), .faultCount(faultCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReq(input int a, input int s, input int p, input int i);
    bit fault;
    string tag;
    @(negedge clk);
    // idle cycle: pulse is gone, captured fields held (R8, R9)
    check("R8 idle pulse", int'(faultPulse), 0);
    check("R8 idle vector", int'(faultVector), 0);
    check("R9 hold addr", int'(faultAddr), expAddr);
    reqAddr = a[ADDR_W-1:0];
    reqSize = s[1:0];
    reqPriv = p[1:0];
    reqImplicitSup = i[0];
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    fault = acFlag && amCtrl && (p == 3) && (i == 0) && ((a % (1 << s)) != 0);
    if (!(acFlag && amCtrl)) tag = "R1 enable";
    else if (p != 3)         tag = "R6 privilege";
    else if (i != 0)         tag = "R7 implicit";
    else if (s == 0)         tag = "R5 byte";
    else if (s == 1)         tag = "R2 half";
    else if (s == 2)         tag = "R3 word";
    else                     tag = "R4 dword";
    if (fault) begin
      expAddr = a;
      expSize = s;
      if (expCount < CMAX) expCount++;
    end
    check(tag, int'(faultPulse), int'(fault));
    check("R8 vector", int'(faultVector), fault ? 17 : 0);
    check("R9 addr", int'(faultAddr), expAddr);
    check("R9 size", int'(faultSize), expSize);
    check("R10 count", int'(faultCount), expCount);
  endtask

  initial begin
    #600000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset ready", int'(reqReady), 0);
    check("R11 reset pulse", int'(faultPulse), 0);
    check("R11 reset count", int'(faultCount), 0);
    check("R11 reset addr", int'(faultAddr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 ready", int'(reqReady), 1);
    for (int ac = 0; ac < 2; ac++) begin
      for (int am = 0; am < 2; am++) begin
        acFlag = ac[0];
        amCtrl = am[0];
        for (int p = 0; p < 4; p++)
          for (int i = 0; i < 2; i++)
            for (int s = 0; s < 4; s++)
              for (int a = 0; a < (1 << ADDR_W); a++)
                doReq(a, s, p, i);
      end
    end
    check("R10 saturated", int'(faultCount), CMAX);
    @(negedge clk);
    check("R8 final idle", int'(faultPulse), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule